// File: doc/BRIEF.md
# Hashed Page Table Walker

On a translation miss, this block looks up one virtual page in a hashed page table held in memory. The caller gives it several inputs at once: a virtual address, an access type, a 24-bit segment identifier, the base address of the table and a hash mask. The walker then reads the table one 32-bit word at a time through a simple request/acknowledge memory port. That port may take any number of cycles to answer.

The walker first searches the group of eight entries that the primary hash selects. If none of them matches, it searches the group that the complemented hash selects. On a match it reads the entry's second word and sets the referenced bit. For writes it also sets the changed bit. It then stores the word back and returns the physical address together with the updated word, so the caller can fill a TLB.

A probe access performs the same search but leaves memory and the TLB untouched. When neither group matches, the walk ends with a miss.

Top module: `pgtbl_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `hit`, `fill` and `mem_req` are all 0.
- R2: The primary hash is `vsid` XOR the zero-extended page index `vaddr[27:12]`. A group starts at ((hash AND `hash_mask`) << 6) OR `tbl_base`. Slot k of a group has its first word at group+8k and its second word at group+8k+4, and slots are read in the order 0 to 7.
- R3: A first word matches when all of the following hold: bit 31 (valid) is 1, bits [30:7] equal `vsid`, bits [5:0] equal `vaddr[27:22]`, and bit 6 is 0 during the primary pass or 1 during the secondary pass.
- R4: When all eight primary slots fail to match, the same scan runs over the group of the complemented hash. The first slot that matches ends the search.
- R5: Access codes are 0 read, 1 write, 2 fetch and 3 probe. For read, write and fetch, bit 8 (referenced) of the second word is set, and a write also sets bit 7 (changed). The updated word is then written back to the second-word address.
- R6: A probe writes nothing to memory and raises no `fill`. It still reports `hit`, `paddr`, and the unmodified second word on `pte_lo`.
- R7: On completion `done` is high for exactly one cycle. In that cycle a hit gives `paddr` = {second word[31:12], `vaddr[11:0]`} and `pte_lo` = the updated second word, and `fill` = `hit` AND (access is not a probe).
- R8: If no match is found in either group, the walk ends with `hit`=0 and `fill`=0 after exactly 16 reads and with no write.
- R9: Memory words are big-endian. The byte at bits [7:0] of `mem_rdata` is the most significant byte of the table word, and `mem_wdata` uses the same byte order.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is sampled high. Any latency is accepted.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 probe |
| vaddr | input | 32 | Virtual address |
| vsid | input | 24 | Virtual segment identifier |
| tbl_base | input | 32 | Table base address, 64-byte aligned |
| hash_mask | input | 24 | Mask applied to the hash |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A matching entry was found |
| fill | output | 1 | Result may be installed in a TLB |
| paddr | output | 32 | Translated physical address |
| pte_lo | output | 32 | Second word of the matched entry, after update |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data in memory byte order |
| mem_ack | input | 1 | Memory has completed the request |
| mem_rdata | input | 32 | Read data in memory byte order, valid with `mem_ack` |

## Verification
The bench sweeps every combination of the two passes, the eight slot positions and the four access types. In each case it plants decoys in front of the target: an entry whose page field is off by one, an invalid copy, and, for secondary targets, a primary group full of entries that match except for a set H bit. A walker with the wrong H polarity or a wrong priority would stop on a decoy, and the exact read count it expects would catch any change in scan order. Memory words are checked after each walk, so a walker that writes back on a probe, forgets the referenced bit, or swaps bytes wrongly is exposed. The miss case and a `start` sent in the middle of a walk cover a walker that stops early or can be restarted while busy.

// File: rtl/pgw_pkg.sv
// Package for the page table walker: access codes, walker states, and the
// bit positions of fields in a table entry.
package pgw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_PROBE = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_WR,
        S_DONE
    } walk_st_e;

    localparam int VLD_BIT = 31;
    localparam int HSEL_BIT = 6;
    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;
endpackage

// File: rtl/pgw_byteswap.sv
// Reverses the byte order of a word. Assumes the word width is a whole
// number of bytes. Purely combinational.
module pgw_byteswap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/pgw_group_addr.sv
// Works out the start address of a hash group for one pass.
// Assumes the base is aligned to a group and that the segment id is at
// least as wide as the page index. Purely combinational.
module pgw_group_addr #(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 24,
    parameter int PIDX_W = 16,
    parameter int GRP_SH = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [VSID_W-1:0] mask,
    input  logic [ADDR_W-1:0] base,
    input  logic              secondary,
    output logic [ADDR_W-1:0] group_addr
);
    logic [VSID_W-1:0] hash_p;
    logic [VSID_W-1:0] hash_sel;

    // Select the primary hash or its complement, then mask, shift and merge with the base.
    always_comb begin
        hash_p     = vsid ^ VSID_W'(pidx);
        hash_sel   = secondary ? ~hash_p : hash_p;
        group_addr = (ADDR_W'(hash_sel & mask) << GRP_SH) | base;
    end
endmodule

// File: rtl/pgw_entry_match.sv
// Checks the first word of an entry (in host byte order) against the request.
// Assumes the entry layout V[31], segment id [30:7], H[6], API [5:0].
module pgw_entry_match #(
    parameter int VSID_W = 24,
    parameter int API_W = 6
) (
    input  logic [31:0]       word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              secondary,
    output logic              hit
);
    import pgw_pkg::*;

    // All four fields must agree for a hit.
    always_comb begin
        hit = word0[VLD_BIT]
              && (word0[HSEL_BIT] == secondary)
              && (word0[HSEL_BIT+1 +: VSID_W] == vsid)
              && (word0[API_W-1:0] == api);
    end
endmodule

// File: rtl/pgtbl_walker.sv
// Hashed page table walker. It scans the primary group and then the
// secondary group, one word read per handshake, and sets the referenced and
// changed bits with a write-back. Probes neither write nor fill.
// Assumes the memory answers every request exactly once with mem_ack, and
// that read data is valid in the cycle mem_ack is high.
module pgtbl_walker #(
    parameter int ADDR_W  = 32,
    parameter int VSID_W  = 24,
    parameter int PIDX_W  = 16,
    parameter int OFF_W   = 12,
    parameter int API_W   = 6,
    parameter int SLOTS   = 8,
    parameter int ENTRY_B = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        acc,
    input  logic [31:0]       vaddr,
    input  logic [VSID_W-1:0] vsid,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [VSID_W-1:0] hash_mask,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              fill,
    output logic [ADDR_W-1:0] paddr,
    output logic [31:0]       pte_lo,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    import pgw_pkg::*;

    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int ENTRY_SH = $clog2(ENTRY_B);
    localparam int GRP_SH   = $clog2(SLOTS * ENTRY_B);
    localparam int VA_W     = OFF_W + PIDX_W;
    localparam int WORD_B   = 4;
    localparam int RPN_W    = ADDR_W - OFF_W;
    localparam int REF_SWP  = 8 * (WORD_B - 1 - REF_BIT / 8) + REF_BIT % 8;

    walk_st_e           st;
    logic [VA_W-1:0]    va_q;
    logic [VSID_W-1:0]  vsid_q;
    logic [VSID_W-1:0]  mask_q;
    logic [ADDR_W-1:0]  base_q;
    acc_e               acc_q;
    logic               pass_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [31:0]        w1_q;
    logic               hit_q;
    logic [ADDR_W-1:0]  paddr_q;

    logic [ADDR_W-1:0]  grp_addr;
    logic [31:0]        rd_word;
    logic               ent_hit;
    logic [31:0]        upd_word;

    pgw_group_addr #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .GRP_SH(GRP_SH)
    ) u_grp (
        .vsid(vsid_q), .pidx(va_q[OFF_W +: PIDX_W]), .mask(mask_q),
        .base(base_q), .secondary(pass_q), .group_addr(grp_addr)
    );

    pgw_byteswap #(.BYTES(WORD_B)) u_rswap (.din(mem_rdata), .dout(rd_word));
    pgw_byteswap #(.BYTES(WORD_B)) u_wswap (.din(w1_q), .dout(mem_wdata));

    pgw_entry_match #(.VSID_W(VSID_W), .API_W(API_W)) u_match (
        .word0(rd_word), .vsid(vsid_q), .api(va_q[VA_W-1 -: API_W]),
        .secondary(pass_q), .hit(ent_hit)
    );

    // Set the referenced and changed bits according to the access type.
    always_comb begin
        upd_word = rd_word;
        if (acc_q != ACC_PROBE) upd_word[REF_BIT] = 1'b1;
        if (acc_q == ACC_WRITE) upd_word[CHG_BIT] = 1'b1;
    end

    // Drive the memory port from the walker state and the current slot.
    always_comb begin
        mem_req  = (st == S_RD0) || (st == S_RD1) || (st == S_WR);
        mem_we   = (st == S_WR);
        mem_addr = grp_addr + (ADDR_W'(slot_q) << ENTRY_SH)
                   + ((st == S_RD0) ? '0 : ADDR_W'(WORD_B));
    end

    assign busy   = (st != S_IDLE);
    assign done   = (st == S_DONE);
    assign hit    = hit_q;
    assign fill   = done && hit_q && (acc_q != ACC_PROBE);
    assign paddr  = paddr_q;
    assign pte_lo = w1_q;

    // Walker state machine: latch the request, scan both groups, update, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            va_q    <= '0;
            vsid_q  <= '0;
            mask_q  <= '0;
            base_q  <= '0;
            acc_q   <= ACC_READ;
            pass_q  <= 1'b0;
            slot_q  <= '0;
            w1_q    <= '0;
            hit_q   <= 1'b0;
            paddr_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    va_q    <= vaddr[VA_W-1:0];
                    vsid_q  <= vsid;
                    mask_q  <= hash_mask;
                    base_q  <= tbl_base;
                    acc_q   <= acc_e'(acc);
                    pass_q  <= 1'b0;
                    slot_q  <= '0;
                    hit_q   <= 1'b0;
                    w1_q    <= '0;
                    paddr_q <= '0;
                    st      <= S_RD0;
                end
                S_RD0: if (mem_ack) begin
                    if (ent_hit) begin
                        st <= S_RD1;
                    end else if (slot_q == SLOT_W'(SLOTS - 1)) begin
                        slot_q <= '0;
                        if (pass_q) st <= S_DONE;
                        else pass_q <= 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                S_RD1: if (mem_ack) begin
                    w1_q    <= upd_word;
                    hit_q   <= 1'b1;
                    paddr_q <= {upd_word[31 -: RPN_W], va_q[OFF_W-1:0]};
                    st      <= (acc_q == ACC_PROBE) ? S_DONE : S_WR;
                end
                S_WR: if (mem_ack) st <= S_DONE;
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r6_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (acc_q != ACC_PROBE));

    a_r5_ref_in_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[REF_SWP]);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_fill_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> (hit && done));

    a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/tb_pgtbl_walker.sv
module tb_pgtbl_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] MASK = 24'h00000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  acc = 2'd0;
    logic [31:0] vaddr = '0;
    logic [23:0] vsid = '0;
    logic [31:0] tbl_base = '0;
    logic [23:0] hash_mask = MASK;
    logic        busy, done, hit, fill;
    logic [31:0] paddr, pte_lo;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem_arr [512];
    int nchk = 0;
    int nerr = 0;
    int rd_cnt, wr_cnt;
    logic r_hit, r_fill, r_busy_seen, r_done_after;
    logic [31:0] r_paddr, r_pte;

    pgtbl_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .acc(acc), .vaddr(vaddr),
        .vsid(vsid), .tbl_base(tbl_base), .hash_mask(hash_mask), .busy(busy),
        .done(done), .hit(hit), .fill(fill), .paddr(paddr), .pte_lo(pte_lo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] gaddr(input logic [23:0] vs, input logic [15:0] pi,
                                          input bit sec, input logic [31:0] base);
        logic [23:0] h;
        h = vs ^ {8'h00, pi};
        if (sec) h = ~h;
        return ({8'h00, h & MASK} << 6) | base;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] w);
        mem_arr[a[10:2]] = bsw(w);
    endtask

    function automatic logic [31:0] get(input logic [31:0] a);
        return bsw(mem_arr[a[10:2]]);
    endfunction

    task automatic clr();
        for (int i = 0; i < 512; i++) mem_arr[i] = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one walk, acting as the memory with a latency that varies per access.
    // When poke_at >= 0, a second start with other inputs is sent at that cycle.
    task automatic walk(input logic [1:0] a, input logic [31:0] va, input logic [23:0] vs,
                        input logic [31:0] base, input int poke_at);
        int cyc, wt, ops;
        cyc = 0; wt = 0; ops = 0;
        rd_cnt = 0; wr_cnt = 0; r_busy_seen = 1'b0;
        @(negedge clk);
        start = 1'b1; acc = a; vaddr = va; vsid = vs; tbl_base = base;
        forever begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (cyc == poke_at) begin
                start = 1'b1; acc = 2'd1; vaddr = ~va; vsid = ~vs;
            end
            if (cyc == 1) r_busy_seen = busy;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wt >= (ops % 4)) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem_arr[mem_addr[10:2]] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem_arr[mem_addr[10:2]];
                        rd_cnt++;
                    end
                    ops++;
                    wt = 0;
                end else begin
                    wt++;
                end
            end
            if (done) begin
                r_hit = hit; r_fill = fill; r_paddr = paddr; r_pte = pte_lo;
                @(negedge clk);
                r_done_after = done;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 hit/fill", {30'b0, hit, fill}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;

        // R8: empty table gives a miss after 16 reads and no write.
        walk(2'd0, 32'h0123_4567, 24'hABCDEF, 32'h0, -1);
        chk("R8 miss hit", {31'b0, r_hit}, 32'd0);
        chk("R8 miss fill", {31'b0, r_fill}, 32'd0);
        chk("R8 miss reads", rd_cnt, 32'd16);
        chk("R8 miss writes", wr_cnt, 32'd0);
        chk("R11 busy after start", {31'b0, r_busy_seen}, 32'd1);
        chk("R7 done one cycle", {31'b0, r_done_after}, 32'd0);

        // Exhaustive sweep over pass, slot and access type, with decoys.
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                for (int a = 0; a < 4; a++) begin
                    int it;
                    logic [23:0] vs;
                    logic [15:0] pi;
                    logic [31:0] va, base, tg, w1, expw, w0;
                    logic [5:0] api;
                    logic [19:0] rpn;
                    it   = p * 32 + s * 4 + a;
                    vs   = 24'h35A000 ^ (24'(it) * 24'h1357);
                    pi   = 16'h1234 + 16'(it) * 16'h0421;
                    va   = {4'h0, pi, 12'hABC ^ 12'(it)};
                    base = it[0] ? 32'h400 : 32'h0;
                    api  = pi[15:10];
                    rpn  = 20'hC0000 + 20'(it) * 20'd77;
                    w1   = {rpn, 12'h012} | ((it % 3 == 0) ? 32'h100 : 32'h0);
                    clr();
                    tg = gaddr(vs, pi, p[0], base);
                    if (p == 1)
                        for (int k = 0; k < 8; k++)
                            put(gaddr(vs, pi, 1'b0, base) + 32'(k * 8), {1'b1, vs, 1'b1, api});
                    if (s > 0) put(tg + 32'((s - 1) * 8), {1'b1, vs, p[0], api ^ 6'h01});
                    if (s > 1) put(tg + 32'((s - 2) * 8), {1'b0, vs, p[0], api});
                    w0 = {1'b1, vs, p[0], api};
                    put(tg + 32'(s * 8), w0);
                    put(tg + 32'(s * 8 + 4), w1);
                    expw = w1;
                    if (a != 3) expw[8] = 1'b1;
                    if (a == 1) expw[7] = 1'b1;
                    walk(2'(a), va, vs, base, -1);
                    chk("R3 R4 hit", {31'b0, r_hit}, 32'd1);
                    chk("R2 R4 scan order reads", rd_cnt, 32'(p * 8 + s + 2));
                    chk("R7 paddr", r_paddr, {rpn, va[11:0]});
                    chk("R5 R6 R9 pte_lo", r_pte, expw);
                    chk("R6 R7 fill", {31'b0, r_fill}, (a != 3) ? 32'd1 : 32'd0);
                    chk("R5 R6 writes", wr_cnt, (a != 3) ? 32'd1 : 32'd0);
                    chk("R5 R9 memory word", get(tg + 32'(s * 8 + 4)), expw);
                end
            end
        end

        // R11: a start pulse in mid-walk must not disturb the walk in progress.
        begin
            logic [31:0] tg;
            clr();
            tg = gaddr(24'h00F00D, 16'h5555, 1'b1, 32'h0);
            put(tg + 32'd56, {1'b1, 24'h00F00D, 1'b1, 6'h15});
            put(tg + 32'd60, 32'h7777_7000);
            walk(2'd0, 32'h0555_5123, 24'h00F00D, 32'h0, 6);
            chk("R11 start ignored paddr", r_paddr, 32'h7777_7123);
            chk("R11 start ignored pte", r_pte, 32'h7777_7100);
            chk("R11 start ignored reads", rd_cnt, 32'd17);
            @(negedge clk);
            chk("R11 idle after done", {31'b0, busy}, 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule